// File: doc/BRIEF.md
# Fixed-Latency Word/Byte Memory with Ready Flag

This block is a small 16-bit memory that takes a fixed number of clock cycles (five by default) to complete each access. A requester drives an address, write data, an enable, a read/write direction and a size select. It then holds them steady until the block raises its ready flag. Ready is high for exactly the last cycle of the access. In that cycle read data is valid, and a write is committed at the clock edge that ends it. The requester typically re-executes the same control step every cycle until it sees ready, then captures the data and moves on.

Each access is sequenced by a three-state machine. **IDLE** waits for the enable. Its transition *start* goes to **COUNT** when enable is seen; this first cycle counts as cycle 1. **COUNT** counts cycles 2 to LAT-1. Its transition *abort* returns to IDLE when enable drops, and its transition *reach* goes to **LAST** once LAT-1 cycles have elapsed. **LAST** is the ready cycle. Its transition *finish* always returns to IDLE, so a request that is still held starts a fresh access on the next cycle. Storage is word-aligned. Byte writes are steered to one of two byte lanes by address bit 0.

Top module: `slowmem_top`

## Requirements
- R1: While reset is active and right after it is released, `ready` is 0, `lane_we` is 2'b00 and `rdata` is 0.
- R2: With `req_en` held high and inputs stable, `ready` is 0 in cycles 1 to 4 of the access and 1 in cycle 5. Cycle 1 is the first cycle in which `req_en` is seen high from idle.
- R3: `ready` is never high in two consecutive cycles. A request held past its ready cycle starts a new five-cycle access, with ready again in its fifth cycle.
- R4: Dropping `req_en` before cycle 5 abandons the access: `ready` stays 0, no storage is changed, and the next access counts from cycle 1.
- R5: In the ready cycle of a read (`req_wr`=0), `rdata` equals the stored 16-bit word at the addressed word. Outside the ready cycle, `rdata` is 0.
- R6: In the ready cycle of a word write (`req_wr`=1, `req_byte`=0), `lane_we` is 2'b11 and the whole `wdata` word is stored.
- R7: In the ready cycle of a byte write (`req_byte`=1), `lane_we` is 2'b10 when `addr[0]`=1 and 2'b01 when `addr[0]`=0. `wdata[7:0]` is stored into that byte (bits 15:8 or 7:0), and the other byte keeps its value.
- R8: `lane_we` is 2'b00 during reads and in every cycle other than a write's ready cycle.
- R9: The word index is `addr[ADDR_W-1:1]`. Word accesses ignore `addr[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Access request, held until ready |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| addr | input | ADDR_W (5) | Byte address; bit 0 selects the byte lane |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read word, valid only while ready is high |
| ready | output | 1 | High during the final cycle of an access |
| lane_we | output | DATA_W/8 (2) | Per-byte write enables |

## Verification
Ready, read data and the lane enables are all due in the fifth cycle counted from the first cycle the request is presented. The write they commit becomes visible at the clock edge that closes that cycle. The bench drives each request just after a falling edge and samples one nanosecond later in every cycle of the access. It expects ready and lane enables to be low for the first four samples and asserted only on the fifth. A written value is checked through a later read's ready cycle, never earlier. Aborted accesses are checked the same way: the bench watches the ports during the short hold, then reads back the word that the aborted write would have changed.

// File: rtl/slowmem_pkg.sv
package slowmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_LAST  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/slowmem_seq.sv
module slowmem_seq
    import slowmem_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_en,
    output logic ready
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(LAT - 1);

    seq_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: start, abort, reach, finish
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_en) begin
                    cnt_d   = CW'(1);
                    state_d = (CW'(1) == LAST_CNT) ? ST_LAST : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!req_en) begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q + CW'(1) == LAST_CNT) state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LAST: ready = req_en;
            default: ready = 1'b0;
        endcase
    end

    // independent count of held request cycles before ready
    logic [CW-1:0] hold_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_q <= '0;
        else if (!req_en || ready)  hold_q <= '0;
        else if (hold_q != LAST_CNT) hold_q <= hold_q + CW'(1);
    end

    p_ready_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (hold_q == LAST_CNT));
    p_ready_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_abort_no_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |=> !ready);

endmodule

// File: rtl/slowmem_lanes.sv
module slowmem_lanes #(
    parameter int DATA_W = 16
) (
    input  logic                   ready,
    input  logic                   req_wr,
    input  logic                   req_byte,
    input  logic [$clog2(DATA_W/8)-1:0] lane_sel,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W/8-1:0]    lane_we,
    output logic [DATA_W-1:0]      lane_data
);
    localparam int NL    = DATA_W / 8;
    localparam int LSB_W = $clog2(NL);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        always_comb begin
            lane_we[i] = ready && req_wr && (!req_byte || lane_sel == LSB_W'(i));
            lane_data[i*8 +: 8] = req_byte ? wdata[7:0] : wdata[i*8 +: 8];
        end
    end

endmodule

// File: rtl/slowmem_store.sv
module slowmem_store #(
    parameter int DATA_W = 16,
    parameter int WAW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W/8-1:0]  lane_we,
    input  logic [WAW-1:0]       word_idx,
    input  logic [DATA_W-1:0]    lane_data,
    output logic [DATA_W-1:0]    word_out
);
    localparam int NL    = DATA_W / 8;
    localparam int DEPTH = 1 << WAW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else begin
            for (int i = 0; i < NL; i++) begin
                if (lane_we[i]) mem[word_idx][i*8 +: 8] <= lane_data[i*8 +: 8];
            end
        end
    end

    assign word_out = mem[word_idx];

endmodule

// File: rtl/slowmem_top.sv
module slowmem_top #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LAT    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_en,
    input  logic                 req_wr,
    input  logic                 req_byte,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ready,
    output logic [DATA_W/8-1:0]  lane_we
);
    localparam int NL    = DATA_W / 8;
    localparam int LSB_W = $clog2(NL);
    localparam int WAW   = ADDR_W - LSB_W;

    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] word_out;

    slowmem_seq #(.LAT(LAT)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_en (req_en),
        .ready  (ready)
    );

    slowmem_lanes #(.DATA_W(DATA_W)) u_lanes (
        .ready     (ready),
        .req_wr    (req_wr),
        .req_byte  (req_byte),
        .lane_sel  (addr[LSB_W-1:0]),
        .wdata     (wdata),
        .lane_we   (lane_we),
        .lane_data (lane_data)
    );

    slowmem_store #(.DATA_W(DATA_W), .WAW(WAW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .word_idx  (addr[ADDR_W-1:LSB_W]),
        .lane_data (lane_data),
        .word_out  (word_out)
    );

    assign rdata = ready ? word_out : '0;

    p_rdata_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (rdata == '0));
    p_we_only_write_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |-> (ready && req_wr));
    p_word_all_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_wr && !req_byte) |-> (lane_we == '1));
    p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_wr && req_byte) |-> ($countones(lane_we) == 1));
    p_we_store_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_wr && !req_byte) |=> (word_out == $past(wdata) || $past(addr[ADDR_W-1:LSB_W]) != addr[ADDR_W-1:LSB_W]));

endmodule

// File: tb/sim_slowmem_top.sv
module sim_slowmem_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0, req_wr = 1'b0, req_byte = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;
    logic [1:0]  lane_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] sh [16];

    always #2 clk = ~clk;

    slowmem_top u0 (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
        .req_byte(req_byte), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .lane_we(lane_we)
    );

    function automatic logic [1:0] exp_we(input logic wr, input logic byt, input logic a0);
        if (!wr) return 2'b00;
        if (!byt) return 2'b11;
        return a0 ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [15:0] exp_word(input logic [15:0] old, input logic byt,
                                             input logic a0, input logic [15:0] d);
        if (!byt) return d;
        return a0 ? {d[7:0], old[7:0]} : {old[15:8], d[7:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // hold a request for n cycles (5 = full access), then drop it
    task automatic run(input logic wr, input logic byt, input logic [4:0] a,
                       input logic [15:0] d, input int n);
        @(negedge clk);
        req_en = 1'b1; req_wr = wr; req_byte = byt; addr = a; wdata = d;
        for (int k = 1; k <= n; k++) begin
            if (k > 1) @(negedge clk);
            #1;
            check(k == 5 ? "R2 ready in cycle 5" : (n < 5 ? "R4 no ready" : "R2 ready low"),
                  ready, (k == 5));
            if (k == 5) begin
                check(wr ? (byt ? "R7 byte lanes" : "R6 word lanes") : "R8 read lanes",
                      lane_we, exp_we(wr, byt, a[0]));
                if (!wr) check(a[0] ? "R9 odd-address read" : "R5 read data",
                               rdata, sh[a[4:1]]);
            end else begin
                check("R8 no early enable", lane_we, 2'b00);
                check("R5 rdata quiet", rdata, 16'h0);
            end
        end
        if (n == 5 && wr) sh[a[4:1]] = exp_word(sh[a[4:1]], byt, a[0], d);
        @(negedge clk);
        req_en = 1'b0;
        #1;
        check("R3 ready not repeated", ready, 1'b0);
        check("R8 enables idle", lane_we, 2'b00);
    endtask

    initial begin
        void'($urandom(32'd4471));
        for (int w = 0; w < 16; w++) sh[w] = 16'h0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 ready in reset", ready, 1'b0);
        check("R1 lane_we in reset", lane_we, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ready after reset", ready, 1'b0);
        check("R1 rdata after reset", rdata, 16'h0);

        // directed corners
        run(1'b1, 1'b0, 5'd7, 16'hBEEF, 5);   // R9 word write, odd address
        run(1'b0, 1'b0, 5'd6, 16'h0, 5);      // R9 read even
        run(1'b1, 1'b1, 5'd6, 16'h0012, 5);   // R7 low lane
        run(1'b1, 1'b1, 5'd7, 16'h0034, 5);   // R7 high lane
        run(1'b0, 1'b0, 5'd7, 16'h0, 5);
        run(1'b1, 1'b0, 5'd2, 16'hAAAA, 3);   // R4 aborted write
        run(1'b0, 1'b0, 5'd2, 16'h0, 5);
        run(1'b1, 1'b0, 5'd2, 16'h1357, 1);   // R4 abort after one cycle
        run(1'b0, 1'b0, 5'd3, 16'h0, 5);

        // R3 back-to-back: held read spans two accesses
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b0; req_byte = 1'b0; addr = 5'd7;
        for (int k = 1; k <= 10; k++) begin
            if (k > 1) @(negedge clk);
            #1;
            check("R3 back-to-back ready", ready, (k % 5 == 0));
        end
        @(negedge clk);
        req_en = 1'b0;

        // constrained random mix
        for (int it = 0; it < 80; it++) begin
            logic wr, byt;
            logic [4:0] a;
            logic [15:0] d;
            int n;
            wr  = $urandom_range(0, 1);
            byt = $urandom_range(0, 1);
            a   = 5'($urandom_range(0, 31));
            d   = 16'($urandom);
            n   = ($urandom_range(0, 9) < 2) ? $urandom_range(1, 4) : 5;
            run(wr, byt, a, d, n);
        end

        // final sweep of storage (R4/R6/R7 committed contents)
        for (int w = 0; w < 16; w++) run(1'b0, 1'b0, 5'(w * 2), 16'h0, 5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule